// File: doc/BRIEF.md
# Multithreaded Issue Queue Entry Allocator

This block tracks how the entries of one shared issue queue are divided among several hardware threads. It does not store instructions. It counts them. Each thread has an occupancy counter. The whole queue has a free-entry counter. A per-thread cap limits how many entries any one thread may hold. An upstream dispatch stage presents one allocation request per cycle, tagged with a thread number. The block grants or rejects that request in the same cycle, from the state held in its registers.

Entries return to the pool through three paths:
- When an issued instruction is not a memory operation, its entry is freed at issue.
- When an issued instruction is a memory operation, its entry is held until a separate completion event frees it.
- A squash frees a given number of a thread's entries at once.

The per-thread cap follows a policy fixed at build time:
- Dynamic sharing lets any thread use the whole queue.
- Partitioning splits the queue evenly among the threads.
- Threshold sharing limits each thread to a set percentage of the queue.

The cap is recomputed whenever the number of active threads changes.

Top module: `iq_share_alloc`

## Requirements
- R1: While reset is held, and in the first cycle after it, free_entries equals N_ENTRIES, every thread's occupancy is zero, queue_full is 0, and the cap is the policy's value for all N_THREADS threads being active.
- R2: Under the dynamic policy (POLICY = SHARE_DYN, encoding 0), every thread's cap is N_ENTRIES whatever the active mask.
- R3: Under the partitioned policy (POLICY = SHARE_PART, encoding 1), the cap is floor(N_ENTRIES / N_THREADS) after reset. After the active count changes to k > 0, the cap is floor(N_ENTRIES / k).
- R4: Under the threshold policy (POLICY = SHARE_THRESH, encoding 2), the cap is floor(THRESH_PCT * N_ENTRIES / 100). When exactly one thread is active, the cap is N_ENTRIES. When the active count changes to any other value above zero, the cap returns to the percentage value.
- R5: thread_free for thread t is its cap minus its occupancy, saturating at 0. thread_full[t] is 1 exactly when that value is 0. Thread t occupies bits [t*CW +: CW] of thread_free, where CW = $clog2(N_ENTRIES+1).
- R6: queue_full is 1 exactly when free_entries is 0.
- R7: alloc_grant is 1 in the same cycle when alloc_valid is 1, queue_full is 0, and thread_full[alloc_tid] is 0. alloc_reject is 1 when alloc_valid is 1 and the grant is withheld. A rejected request changes no count.
- R8: An issue event with issue_mem = 0 frees one entry of issue_tid. An issue event with issue_mem = 1 frees nothing.
- R9: A done event (memory completion) frees one entry of done_tid.
- R10: A squash event frees squash_cnt entries of squash_tid in the cycle it is presented. The amount is clamped so that no thread's occupancy goes below zero. Releases from all paths in one cycle are combined.
- R11: free_entries always equals N_ENTRIES minus the sum of all thread occupancies.
- R12: A change of the active-thread count sets a new cap at the next clock edge. In the cycle the new mask is first presented, the old cap still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_mask | input | N_THREADS | One bit per thread that is currently running |
| alloc_valid | input | 1 | Request one entry for alloc_tid |
| alloc_tid | input | TW | Thread of the allocation request |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_reject | output | 1 | Request refused this cycle (queue or thread full) |
| issue_valid | input | 1 | An instruction of issue_tid issued |
| issue_mem | input | 1 | The issued instruction is a memory operation (entry kept) |
| issue_tid | input | TW | Thread of the issued instruction |
| done_valid | input | 1 | A memory operation of done_tid completed |
| done_tid | input | TW | Thread of the completed memory operation |
| squash_valid | input | 1 | Squash a group of entries of squash_tid |
| squash_tid | input | TW | Thread being squashed |
| squash_cnt | input | CW | Number of entries freed by the squash |
| free_entries | output | CW | Free entries in the whole queue |
| queue_full | output | 1 | No free entry is left |
| thread_full | output | N_THREADS | Per-thread full flag |
| thread_free | output | N_THREADS*CW | Per-thread free count, packed by thread |

## Verification
Grant and reject are combinational from registered state. The bench therefore samples them one time unit after it drives a request, before the clock edge that would consume it. Occupancy, free counts and both full flags change at the edge that takes in an event. The bench reads them one time unit after that edge, when the request inputs have already been dropped. A new cap appears only after the edge that first sees a changed active count. The bench checks the old cap just before that edge and the new cap just after it.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;

   typedef enum logic [1:0] {
      SHARE_DYN    = 2'd0,
      SHARE_PART   = 2'd1,
      SHARE_THRESH = 2'd2
   } share_policy_e;

   // Cap per thread for a given policy and number of active threads.
   function automatic int share_cap(share_policy_e pol, int n, int pct, int act);
      int cap;
      case (pol)
         SHARE_PART:   cap = n / act;
         SHARE_THRESH: cap = (act == 1) ? n : (pct * n) / 100;
         default:      cap = n;
      endcase
      return cap;
   endfunction

endpackage

// File: rtl/iq_cap_calc.sv
module iq_cap_calc
   import iq_alloc_pkg::*;
#(
   parameter int            N_ENTRIES  = 16,
   parameter int            N_THREADS  = 4,
   parameter share_policy_e POLICY     = SHARE_PART,
   parameter int            THRESH_PCT = 25,
   localparam int           CW         = $clog2(N_ENTRIES + 1),
   localparam int           AW         = $clog2(N_THREADS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_THREADS-1:0] active_mask,
   output logic [CW-1:0]        cap_q
);

   localparam logic [CW-1:0] RST_CAP = CW'(share_cap(POLICY, N_ENTRIES, THRESH_PCT, N_THREADS));
   localparam logic [AW-1:0] RST_ACT = AW'(N_THREADS);

   logic [CW-1:0] cap_lut [N_THREADS];
   logic [AW-1:0] act_cnt;
   logic [AW-1:0] act_q;
   logic [CW-1:0] cap_sel;

   // One constant per possible active count; no divider in hardware.
   for (genvar k = 0; k < N_THREADS; k++) begin : g_lut
      assign cap_lut[k] = CW'(share_cap(POLICY, N_ENTRIES, THRESH_PCT, k + 1));
   end

   always_comb begin
      act_cnt = '0;
      for (int i = 0; i < N_THREADS; i++) begin
         act_cnt = act_cnt + AW'(active_mask[i]);
      end
   end

   always_comb begin
      cap_sel = cap_q;
      for (int k = 0; k < N_THREADS; k++) begin
         if (act_cnt == AW'(k + 1)) begin
            cap_sel = cap_lut[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q <= RST_CAP;
         act_q <= RST_ACT;
      end else if ((act_cnt != act_q) && (act_cnt != '0)) begin
         cap_q <= cap_sel;
         act_q <= act_cnt;
      end
   end

endmodule

// File: rtl/iq_thread_occ.sv
module iq_thread_occ #(
   parameter int  N_ENTRIES = 16,
   localparam int CW        = $clog2(N_ENTRIES + 1),
   localparam int RW        = CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [RW-1:0] give_req,
   input  logic [CW-1:0] cap,
   output logic [CW-1:0] occ_q,
   output logic [CW-1:0] rel,
   output logic [CW-1:0] free,
   output logic          full
);

   // Never release more than is held.
   always_comb begin
      if (give_req > RW'(occ_q)) begin
         rel = occ_q;
      end else begin
         rel = give_req[CW-1:0];
      end
   end

   // Saturate: a shrunken cap may fall below the occupancy.
   always_comb begin
      if (cap > occ_q) begin
         free = cap - occ_q;
      end else begin
         free = '0;
      end
   end

   assign full = (free == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else begin
         occ_q <= occ_q - rel + CW'(take);
      end
   end

endmodule

// File: rtl/iq_free_ctr.sv
module iq_free_ctr #(
   parameter int  N_ENTRIES = 16,
   parameter int  N_THREADS = 4,
   localparam int CW        = $clog2(N_ENTRIES + 1),
   localparam int TW        = $clog2(N_THREADS),
   localparam int SW        = CW + TW + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  logic [N_THREADS*CW-1:0]   rel_flat,
   output logic [CW-1:0]             free_q
);

   logic [SW-1:0] rel_sum;
   logic [SW-1:0] free_nxt;

   always_comb begin
      rel_sum = '0;
      for (int i = 0; i < N_THREADS; i++) begin
         rel_sum = rel_sum + SW'(rel_flat[i*CW +: CW]);
      end
      free_nxt = SW'(free_q) + rel_sum - SW'(take);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= CW'(N_ENTRIES);
      end else begin
         free_q <= free_nxt[CW-1:0];
      end
   end

endmodule

// File: rtl/iq_share_alloc.sv
module iq_share_alloc
   import iq_alloc_pkg::*;
#(
   parameter int            N_ENTRIES  = 16,
   parameter int            N_THREADS  = 4,
   parameter share_policy_e POLICY     = SHARE_PART,
   parameter int            THRESH_PCT = 25,
   localparam int           CW         = $clog2(N_ENTRIES + 1),
   localparam int           TW         = $clog2(N_THREADS),
   localparam int           RW         = CW + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_THREADS-1:0]    active_mask,
   input  logic                    alloc_valid,
   input  logic [TW-1:0]           alloc_tid,
   output logic                    alloc_grant,
   output logic                    alloc_reject,
   input  logic                    issue_valid,
   input  logic                    issue_mem,
   input  logic [TW-1:0]           issue_tid,
   input  logic                    done_valid,
   input  logic [TW-1:0]           done_tid,
   input  logic                    squash_valid,
   input  logic [TW-1:0]           squash_tid,
   input  logic [CW-1:0]           squash_cnt,
   output logic [CW-1:0]           free_entries,
   output logic                    queue_full,
   output logic [N_THREADS-1:0]    thread_full,
   output logic [N_THREADS*CW-1:0] thread_free
);

   // Elaboration-time parameter checks
   if (N_THREADS < 2 || (1 << TW) != N_THREADS) begin : g_bad_threads
      $error("iq_share_alloc: N_THREADS must be a power of two, at least 2");
   end
   if (N_ENTRIES < N_THREADS) begin : g_bad_entries
      $error("iq_share_alloc: N_ENTRIES must be at least N_THREADS");
   end
   if (THRESH_PCT < 1 || THRESH_PCT > 100) begin : g_bad_pct
      $error("iq_share_alloc: THRESH_PCT must lie in 1..100");
   end

   logic [CW-1:0]           cap_q;
   logic [N_THREADS*CW-1:0] occ_flat;
   logic [N_THREADS*CW-1:0] rel_flat;

   iq_cap_calc #(
      .N_ENTRIES  (N_ENTRIES),
      .N_THREADS  (N_THREADS),
      .POLICY     (POLICY),
      .THRESH_PCT (THRESH_PCT)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_mask (active_mask),
      .cap_q       (cap_q)
   );

   assign queue_full   = (free_entries == '0);
   assign alloc_grant  = alloc_valid && !queue_full && !thread_full[alloc_tid];
   assign alloc_reject = alloc_valid && !alloc_grant;

   for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
      logic          take;
      logic [RW-1:0] give_req;
      logic [CW-1:0] free_t;

      assign take     = alloc_grant && (alloc_tid == TW'(t));
      assign give_req = RW'(issue_valid && !issue_mem && (issue_tid == TW'(t)))
                      + RW'(done_valid && (done_tid == TW'(t)))
                      + ((squash_valid && (squash_tid == TW'(t))) ? RW'(squash_cnt) : RW'(0));

      iq_thread_occ #(
         .N_ENTRIES (N_ENTRIES)
      ) u_occ (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take),
         .give_req (give_req),
         .cap      (cap_q),
         .occ_q    (occ_flat[t*CW +: CW]),
         .rel      (rel_flat[t*CW +: CW]),
         .free     (free_t),
         .full     (thread_full[t])
      );

      assign thread_free[t*CW +: CW] = free_t;
   end

   iq_free_ctr #(
      .N_ENTRIES (N_ENTRIES),
      .N_THREADS (N_THREADS)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (alloc_grant),
      .rel_flat (rel_flat),
      .free_q   (free_entries)
   );

endmodule

// File: rtl/iq_share_alloc_chk.sv
module iq_share_alloc_chk #(
   parameter int  N_ENTRIES = 16,
   parameter int  N_THREADS = 4,
   localparam int CW        = $clog2(N_ENTRIES + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    alloc_valid,
   input logic                    alloc_grant,
   input logic                    alloc_reject,
   input logic                    issue_valid,
   input logic                    issue_mem,
   input logic                    done_valid,
   input logic                    squash_valid,
   input logic                    queue_full,
   input logic [CW-1:0]           free_entries,
   input logic [CW-1:0]           cap_q,
   input logic [N_THREADS*CW-1:0] occ_flat
);

   int occ_sum;
   logic no_release;

   always_comb begin
      occ_sum = 0;
      for (int i = 0; i < N_THREADS; i++) begin
         occ_sum = occ_sum + int'(occ_flat[i*CW +: CW]);
      end
   end

   assign no_release = !issue_valid && !done_valid && !squash_valid;

   p_free_sum_r11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_entries) == N_ENTRIES - occ_sum);

   p_one_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_grant && alloc_reject));

   p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_full && alloc_valid) |-> alloc_reject);

   p_grant_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_grant && no_release) |=> (free_entries == $past(free_entries) - CW'(1)));

   p_mem_issue_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_mem && !alloc_valid && !done_valid && !squash_valid)
         |=> $stable(free_entries));

   p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cap_q) <= N_ENTRIES);

endmodule

bind iq_share_alloc iq_share_alloc_chk #(
   .N_ENTRIES (N_ENTRIES),
   .N_THREADS (N_THREADS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_valid  (alloc_valid),
   .alloc_grant  (alloc_grant),
   .alloc_reject (alloc_reject),
   .issue_valid  (issue_valid),
   .issue_mem    (issue_mem),
   .done_valid   (done_valid),
   .squash_valid (squash_valid),
   .queue_full   (queue_full),
   .free_entries (free_entries),
   .cap_q        (cap_q),
   .occ_flat     (occ_flat)
);

// File: tb/iq_share_alloc_tb_top.sv
module iq_share_alloc_tb_top;
   import iq_alloc_pkg::*;

   localparam int N  = 8;
   localparam int T  = 4;
   localparam int CW = 4;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [T-1:0]  active_mask = '1;
   logic          alloc_valid = 1'b0;
   logic [TW-1:0] alloc_tid = '0;
   logic          issue_valid = 1'b0;
   logic          issue_mem = 1'b0;
   logic [TW-1:0] issue_tid = '0;
   logic          done_valid = 1'b0;
   logic [TW-1:0] done_tid = '0;
   logic          squash_valid = 1'b0;
   logic [TW-1:0] squash_tid = '0;
   logic [CW-1:0] squash_cnt = '0;

   logic          part_grant, part_reject, part_qfull;
   logic [CW-1:0] part_free;
   logic [T-1:0]  part_tfull;
   logic [T*CW-1:0] part_tfree;
   logic          dyn_grant, dyn_reject, dyn_qfull;
   logic [CW-1:0] dyn_free;
   logic [T-1:0]  dyn_tfull;
   logic [T*CW-1:0] dyn_tfree;
   logic          thr_grant, thr_reject, thr_qfull;
   logic [CW-1:0] thr_free;
   logic [T-1:0]  thr_tfull;
   logic [T*CW-1:0] thr_tfree;

   iq_share_alloc #(.N_ENTRIES(N), .N_THREADS(T), .POLICY(SHARE_PART), .THRESH_PCT(50)) dut_i (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
      .alloc_grant(part_grant), .alloc_reject(part_reject),
      .issue_valid(issue_valid), .issue_mem(issue_mem), .issue_tid(issue_tid),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .free_entries(part_free), .queue_full(part_qfull),
      .thread_full(part_tfull), .thread_free(part_tfree));

   iq_share_alloc #(.N_ENTRIES(N), .N_THREADS(T), .POLICY(SHARE_DYN), .THRESH_PCT(50)) dut_dyn (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
      .alloc_grant(dyn_grant), .alloc_reject(dyn_reject),
      .issue_valid(issue_valid), .issue_mem(issue_mem), .issue_tid(issue_tid),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .free_entries(dyn_free), .queue_full(dyn_qfull),
      .thread_full(dyn_tfull), .thread_free(dyn_tfree));

   iq_share_alloc #(.N_ENTRIES(N), .N_THREADS(T), .POLICY(SHARE_THRESH), .THRESH_PCT(50)) dut_thr (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
      .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
      .alloc_grant(thr_grant), .alloc_reject(thr_reject),
      .issue_valid(issue_valid), .issue_mem(issue_mem), .issue_tid(issue_tid),
      .done_valid(done_valid), .done_tid(done_tid),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
      .free_entries(thr_free), .queue_full(thr_qfull),
      .thread_full(thr_tfull), .thread_free(thr_tfree));

   // Stimulus vectors for dut_i (partitioned, cap 2 with all four threads active)
   typedef struct packed {
      logic          av;  logic [TW-1:0] at;
      logic          iv;  logic im; logic [TW-1:0] it;
      logic          dv;  logic [TW-1:0] dt;
      logic          sv;  logic [TW-1:0] st; logic [CW-1:0] sc;
      logic          eg;  logic [CW-1:0] ef;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd7, 4'd7},
      '{1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd6, 4'd7},
      '{1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd6, 4'd5},
      '{1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd6, 4'd8},
      '{1'b1, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd5, 4'd8},
      '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd6, 4'd9},
      '{1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd5, 4'd7},
      '{1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd4, 4'd7},
      '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 4'd3, 1'b0, 4'd6, 4'd10},
      '{1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd5, 4'd7},
      '{1'b1, 2'd3, 1'b1, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 1'b1, 4'd5, 4'd8}
   };

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int slot(input logic [T*CW-1:0] flat, input int i);
      return int'(flat[i*CW +: CW]);
   endfunction

   task automatic idle_inputs();
      alloc_valid = 1'b0; issue_valid = 1'b0; issue_mem = 1'b0;
      done_valid = 1'b0; squash_valid = 1'b0; squash_cnt = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      idle_inputs();
      #1;
   endtask

   task automatic new_mask(input logic [T-1:0] m);
      @(negedge clk);
      active_mask = m;
      tick();
   endtask

   task automatic alloc_one(input int tid);
      @(negedge clk);
      alloc_valid = 1'b1;
      alloc_tid   = TW'(tid);
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      do_reset();
      #1;
      // Reset state, R1 plus the reset cap of each policy (R2, R3, R4)
      check(part_free == 4'd8 && dyn_free == 4'd8 && thr_free == 4'd8, "R1 free_entries", int'(part_free), 8);
      check(!part_qfull && !dyn_qfull && !thr_qfull, "R1 queue_full", int'(part_qfull), 0);
      check(slot(dyn_tfree, 3) == 8, "R2 dynamic cap", slot(dyn_tfree, 3), 8);
      check(slot(part_tfree, 1) == 2, "R3 partitioned reset cap", slot(part_tfree, 1), 2);
      check(slot(thr_tfree, 2) == 4, "R4 threshold cap", slot(thr_tfree, 2), 4);

      // Vector table: grant due in the request cycle, counts one edge later
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         alloc_valid  = VEC[v].av; alloc_tid = VEC[v].at;
         issue_valid  = VEC[v].iv; issue_mem = VEC[v].im; issue_tid = VEC[v].it;
         done_valid   = VEC[v].dv; done_tid  = VEC[v].dt;
         squash_valid = VEC[v].sv; squash_tid = VEC[v].st; squash_cnt = VEC[v].sc;
         #1;
         check(part_grant == VEC[v].eg, $sformatf("R7 grant vector %0d", v), int'(part_grant), int'(VEC[v].eg));
         tick();
         check(part_free == VEC[v].ef, $sformatf("R%0d free_entries vector %0d", VEC[v].req, v),
               int'(part_free), int'(VEC[v].ef));
      end

      // Cap recomputation on active-count changes (R12, R3, R4)
      do_reset();
      @(negedge clk);
      active_mask = 4'b0011;
      #1;
      check(slot(part_tfree, 0) == 2, "R12 old cap before edge", slot(part_tfree, 0), 2);
      tick();
      check(slot(part_tfree, 0) == 4, "R12 R3 cap after change to 2 active", slot(part_tfree, 0), 4);
      check(slot(thr_tfree, 0) == 4, "R4 threshold with 2 active", slot(thr_tfree, 0), 4);
      new_mask(4'b0001);
      check(slot(part_tfree, 0) == 8, "R3 cap with 1 active", slot(part_tfree, 0), 8);
      check(slot(thr_tfree, 0) == 8, "R4 single thread gets whole queue", slot(thr_tfree, 0), 8);
      check(slot(dyn_tfree, 0) == 8, "R2 dynamic unchanged", slot(dyn_tfree, 0), 8);
      new_mask(4'b1111);
      check(slot(thr_tfree, 0) == 4, "R4 threshold restored", slot(thr_tfree, 0), 4);
      check(slot(part_tfree, 0) == 2, "R3 cap back to 2", slot(part_tfree, 0), 2);

      // Fill the queue with one thread, then shrink the cap
      new_mask(4'b0001);
      for (int i = 0; i < 8; i++) alloc_one(0);
      check(dyn_free == 4'd0 && dyn_qfull, "R6 queue_full at zero free", int'(dyn_qfull), 1);
      check(part_qfull && thr_qfull, "R6 queue_full other policies", int'(part_qfull), 1);
      new_mask(4'b1111);
      check(slot(part_tfree, 0) == 0 && part_tfull[0], "R5 saturated free count", slot(part_tfree, 0), 0);
      check(slot(thr_tfree, 0) == 0 && thr_tfull[0], "R5 saturated threshold", slot(thr_tfree, 0), 0);
      check(slot(part_tfree, 1) == 2 && !part_tfull[1], "R5 idle thread free count", slot(part_tfree, 1), 2);
      @(negedge clk);
      alloc_valid = 1'b1;
      alloc_tid   = 2'd1;
      #1;
      check(part_reject && !part_grant, "R7 reject on full queue", int'(part_reject), 1);
      tick();
      check(part_free == 4'd0 && slot(part_tfree, 1) == 2, "R7 rejected request changes nothing", int'(part_free), 0);

      // Squash release and release on an empty thread
      @(negedge clk);
      squash_valid = 1'b1; squash_tid = 2'd0; squash_cnt = 4'd5;
      tick();
      check(dyn_free == 4'd5 && part_free == 4'd5, "R10 squash frees entries", int'(dyn_free), 5);
      check(!dyn_qfull, "R6 queue_full clears", int'(dyn_qfull), 0);
      @(negedge clk);
      issue_valid = 1'b1; issue_mem = 1'b0; issue_tid = 2'd3;
      tick();
      check(dyn_free == 4'd5, "R8 release on empty thread clamped", int'(dyn_free), 5);
      @(negedge clk);
      done_valid = 1'b1; done_tid = 2'd0;
      tick();
      check(dyn_free == 4'd6 && slot(dyn_tfree, 0) == 6, "R9 completion frees entry", int'(dyn_free), 6);

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule